// File: doc/BRIEF.md
# Command Ring Pointer Controller

This block keeps the pointer and control state for one command/response ring of a host controller. Software places command descriptors in memory, then moves the enqueue pointer forward through a register write. A transfer engine, abstracted here as a one-cycle "command consumed" strobe, works through the ring. Each strobe it gives while commands are pending moves a hardware dequeue pointer forward. Software acknowledges responses through its own dequeue pointer field. Descriptor fetch, bus signalling and memory traffic stay outside the block.

All state sits behind a 32-bit register bus with a single-cycle write strobe and a combinational read port. The registers hold the ring size, the control bits (enable, run/stop, abort), a status view, and an interrupt group with latched status, status-enable, signal-enable and force. Writing abort halts command processing. One cycle later the ring reports itself halted and raises a ring-operation interrupt.

Top module: `crp_ring_ctrl`

## Requirements
- R1: After reset every register reads 0. The ring size sits at offset 0x00, bits 8:0, and reads back as written.
- R2: The operation-1 register at 0x28 holds the command enqueue pointer in bits 7:0, the software response dequeue pointer in bits 15:8 and the IBI dequeue pointer in bits 23:16. All three are written and read back.
- R3: The operation-2 register at 0x2C returns the hardware dequeue pointer in bits 7:0. Its IBI enqueue field (bits 23:16) reads 0, and writes to 0x2C change nothing.
- R4: `cmd_pending` is high exactly when control (0x24) enable bit 0 and run bit 1 are set, no abort is in progress or held, and the hardware dequeue pointer differs from the enqueue pointer.
- R5: A consume strobe while `cmd_pending` is high moves the hardware dequeue pointer forward by one. The pointer wraps to 0 when the incremented value equals the ring size. A strobe while `cmd_pending` is low is ignored.
- R6: Once control enable reads 0 at a clock edge, the hardware dequeue pointer is 0 after that edge.
- R7: Writing control with bit 2 set stops processing. One cycle later ring status (0x20) shows locked (bit 3) and not running. One cycle after that it shows aborted (bit 2) with locked clear, and the ring-operation interrupt (bit 10) latches. A later control write with bit 2 clear leaves the aborted state.
- R8: Ring status bit 0 mirrors control enable. Bit 1 (running) is set when enable and run are set and the ring is not halting or halted.
- R9: Interrupt status (0x10) has bits 12, 11, 10, 9, 7, 6 and 5. A hardware event latches only when its bit in status-enable (0x14) is set. Each accepted consume is a transfer-completion event on bit 11. Writing 1 clears a bit, and a latching event in the same cycle wins over the clear.
- R10: Writing 1 to a bit of the force register (0x1C) sets that status bit whatever the status-enable setting. The force register reads 0.
- R11: `irq` is high when any status bit is set together with its signal-enable (0x18) bit.
- R12: Bits outside the defined fields, and unmapped offsets, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | Access is a write when high |
| bus_addr | input | 8 | Byte offset of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| eng_consume | input | 1 | Transfer engine consumed one command |
| cmd_pending | output | 1 | Ring running and not empty |
| irq | output | 1 | Interrupt request |

## Verification
The consume strobe is tried in four situations: with the ring stopped, with it running and holding commands, with it empty, and across the wrap point of a five-entry ring. These cases separate acceptance gating, empty detection and the modulo step. Interrupt behaviour is tried with status-enable both set and clear, with force writes, and with a write-one clear in the same cycle as a completion, which shows the priority between set and clear. An abort sequence and an enable drop are each followed cycle by cycle through the status view and the pointer register.

// File: rtl/crp_pkg.sv
package crp_pkg;

    localparam int PTR_W  = 8;
    localparam int SIZE_W = PTR_W + 1;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_SETUP = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ISTS  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_ISIG  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IFRC  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_RSTAT = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RCTRL = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_OP1   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_OP2   = 8'h2C;

    localparam int IRQ_IBI_RDY   = 12;
    localparam int IRQ_XFER_DONE = 11;
    localparam int IRQ_RING_OP   = 10;
    localparam int IRQ_XFER_ERR  = 9;
    localparam int IRQ_STOP_INS  = 7;
    localparam int IRQ_IBI_FULL  = 6;
    localparam int IRQ_XFER_ABT  = 5;

    localparam logic [DATA_W-1:0] IRQ_MASK =
        (DATA_W'(1) << IRQ_IBI_RDY)  | (DATA_W'(1) << IRQ_XFER_DONE) |
        (DATA_W'(1) << IRQ_RING_OP)  | (DATA_W'(1) << IRQ_XFER_ERR)  |
        (DATA_W'(1) << IRQ_STOP_INS) | (DATA_W'(1) << IRQ_IBI_FULL)  |
        (DATA_W'(1) << IRQ_XFER_ABT);

    typedef enum logic [1:0] {
        RS_NORMAL  = 2'd0,
        RS_HALTING = 2'd1,
        RS_HALTED  = 2'd2
    } ring_state_e;

    typedef struct packed {
        logic abort;
        logic run;
        logic enable;
    } ring_ctrl_t;

    typedef struct packed {
        logic [PTR_W-1:0] ibi_deq;
        logic [PTR_W-1:0] sw_deq;
        logic [PTR_W-1:0] enq;
    } op1_t;

    function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p,
                                                   input logic [SIZE_W-1:0] sz);
        logic [SIZE_W-1:0] n;
        n = {1'b0, p} + SIZE_W'(1);
        if (n == sz) return '0;
        return n[PTR_W-1:0];
    endfunction

endpackage

// File: rtl/crp_ctrl_unit.sv
module crp_ctrl_unit
    import crp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  ring_ctrl_t ctrl_d,
    output ring_ctrl_t ctrl_q,
    output logic       running_o,
    output logic       locked_o,
    output logic       aborted_o,
    output logic       op_done_o
);
    ring_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RS_NORMAL:  if (ctrl_we && ctrl_d.abort)  state_n = RS_HALTING;
            RS_HALTING: state_n = RS_HALTED;
            RS_HALTED:  if (ctrl_we && !ctrl_d.abort) state_n = RS_NORMAL;
            default:    state_n = RS_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            state_q <= RS_NORMAL;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_d;
            state_q <= state_n;
        end
    end

    assign running_o = ctrl_q.enable && ctrl_q.run && (state_q == RS_NORMAL);
    assign locked_o  = (state_q == RS_HALTING);
    assign aborted_o = (state_q == RS_HALTED);
    assign op_done_o = (state_q == RS_HALTING);

    // R7
    abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && ctrl_d.abort) |=> !running_o);

    // R7
    halt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> (aborted_o && !locked_o));

endmodule

// File: rtl/crp_ptr_unit.sv
module crp_ptr_unit
    import crp_pkg::*;
#(
    parameter int PW = crp_pkg::PTR_W,
    parameter int SW = crp_pkg::SIZE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op1_we,
    input  op1_t          op1_d,
    input  logic          size_we,
    input  logic [SW-1:0] size_d,
    input  logic          enable_i,
    input  logic          running_i,
    input  logic          consume_i,
    output op1_t          op1_q,
    output logic [SW-1:0] size_q,
    output logic [PW-1:0] hw_deq_o,
    output logic          pending_o,
    output logic          accept_o
);
    assign pending_o = running_i && (hw_deq_o != op1_q.enq);
    assign accept_o  = consume_i && pending_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            op1_q    <= '0;
            size_q   <= '0;
            hw_deq_o <= '0;
        end else begin
            if (op1_we)  op1_q  <= op1_d;
            if (size_we) size_q <= size_d;
            if (!enable_i)     hw_deq_o <= '0;
            else if (accept_o) hw_deq_o <= ring_next(hw_deq_o, size_q);
        end
    end

    // R6
    deq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (hw_deq_o == '0));

    // R5
    deq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable_i && !consume_i) |=> $stable(hw_deq_o));

endmodule

// File: rtl/crp_irq_unit.sv
module crp_irq_unit
    import crp_pkg::*;
#(
    parameter int                DW   = crp_pkg::DATA_W,
    parameter logic [DW-1:0]     MASK = crp_pkg::IRQ_MASK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sts_we,
    input  logic          sen_we,
    input  logic          sig_we,
    input  logic          frc_we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] hw_set,
    output logic [DW-1:0] sts_q,
    output logic [DW-1:0] sen_q,
    output logic [DW-1:0] sig_q,
    output logic          irq_o
);
    logic unused_bits;
    assign unused_bits = ^{hw_set & ~MASK, wdata & ~MASK};

    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (MASK[b]) begin : g_live
            logic set_b, clr_b;
            assign set_b = (hw_set[b] && sen_q[b]) || (frc_we && wdata[b]);
            assign clr_b = sts_we && wdata[b];

            always_ff @(posedge clk) begin
                if (rst) begin
                    sts_q[b] <= 1'b0;
                    sen_q[b] <= 1'b0;
                    sig_q[b] <= 1'b0;
                end else begin
                    if (set_b)      sts_q[b] <= 1'b1;
                    else if (clr_b) sts_q[b] <= 1'b0;
                    if (sen_we) sen_q[b] <= wdata[b];
                    if (sig_we) sig_q[b] <= wdata[b];
                end
            end

            // R9
            latch_chk: assert property (@(posedge clk) disable iff (rst)
                (hw_set[b] && sen_q[b]) |=> sts_q[b]);

            // R10
            force_chk: assert property (@(posedge clk) disable iff (rst)
                (frc_we && wdata[b]) |=> sts_q[b]);
        end else begin : g_tie
            assign sts_q[b] = 1'b0;
            assign sen_q[b] = 1'b0;
            assign sig_q[b] = 1'b0;
        end
    end

    assign irq_o = |(sts_q & sig_q);

endmodule

// File: rtl/crp_ring_ctrl.sv
module crp_ring_ctrl
    import crp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_consume,
    output logic              cmd_pending,
    output logic              irq
);
    logic wr;
    assign wr = bus_valid && bus_write;

    ring_ctrl_t        ctrl_q;
    logic              running, locked, aborted, op_done;
    op1_t              op1_q;
    logic [SIZE_W-1:0] size_q;
    logic [PTR_W-1:0]  hw_deq;
    logic              accept;
    logic [DATA_W-1:0] sts_q, sen_q, sig_q, hw_set;

    crp_ctrl_unit u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (wr && bus_addr == OFS_RCTRL),
        .ctrl_d    (ring_ctrl_t'(bus_wdata[2:0])),
        .ctrl_q    (ctrl_q),
        .running_o (running),
        .locked_o  (locked),
        .aborted_o (aborted),
        .op_done_o (op_done)
    );

    crp_ptr_unit u_ptr (
        .clk       (clk),
        .rst       (rst),
        .op1_we    (wr && bus_addr == OFS_OP1),
        .op1_d     (op1_t'(bus_wdata[3*PTR_W-1:0])),
        .size_we   (wr && bus_addr == OFS_SETUP),
        .size_d    (bus_wdata[SIZE_W-1:0]),
        .enable_i  (ctrl_q.enable),
        .running_i (running),
        .consume_i (eng_consume),
        .op1_q     (op1_q),
        .size_q    (size_q),
        .hw_deq_o  (hw_deq),
        .pending_o (cmd_pending),
        .accept_o  (accept)
    );

    always_comb begin
        hw_set = '0;
        hw_set[IRQ_XFER_DONE] = accept;
        hw_set[IRQ_RING_OP]   = op_done;
    end

    crp_irq_unit u_irq (
        .clk    (clk),
        .rst    (rst),
        .sts_we (wr && bus_addr == OFS_ISTS),
        .sen_we (wr && bus_addr == OFS_IEN),
        .sig_we (wr && bus_addr == OFS_ISIG),
        .frc_we (wr && bus_addr == OFS_IFRC),
        .wdata  (bus_wdata),
        .hw_set (hw_set),
        .sts_q  (sts_q),
        .sen_q  (sen_q),
        .sig_q  (sig_q),
        .irq_o  (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_SETUP: bus_rdata = DATA_W'(size_q);
            OFS_ISTS:  bus_rdata = sts_q;
            OFS_IEN:   bus_rdata = sen_q;
            OFS_ISIG:  bus_rdata = sig_q;
            OFS_RSTAT: bus_rdata = DATA_W'({locked, aborted, running, ctrl_q.enable});
            OFS_RCTRL: bus_rdata = DATA_W'(ctrl_q);
            OFS_OP1:   bus_rdata = DATA_W'(op1_q);
            OFS_OP2:   bus_rdata = DATA_W'(hw_deq);
            default:   bus_rdata = '0;
        endcase
    end

    // R4
    pend_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_pending |-> (ctrl_q.enable && ctrl_q.run && !locked && !aborted));

    // R9
    done_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_consume && cmd_pending && sen_q[IRQ_XFER_DONE]) |=> sts_q[IRQ_XFER_DONE]);

endmodule

// File: tb/crp_ring_ctrl_tb.sv
`timescale 1ns/1ps
module crp_ring_ctrl_tb_top;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        eng_consume = 1'b0;
    logic        cmd_pending;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(HALF) clk = ~clk;

    crp_ring_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_consume(eng_consume), .cmd_pending(cmd_pending), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    localparam logic [31:0] M_MASK = 32'h0000_1EE0;
    int unsigned m_size, m_ctrl, m_enq, m_swdeq, m_ibideq, m_hwdeq, m_state;
    logic [31:0] m_sts, m_sen, m_sig;
    bit m_wr, m_acc, m_opd;
    int unsigned m_nstate;
    logic [31:0] m_set, m_clr;

    function automatic bit m_pending();
        return (m_ctrl[0] && m_ctrl[1] && m_state == 0 && m_hwdeq != m_enq);
    endfunction

    function automatic int unsigned m_next(int unsigned p);
        int unsigned n = p + 1;
        if (n == m_size) return 0;
        return n % 256;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h00: return m_size;
            8'h10: return m_sts;
            8'h14: return m_sen;
            8'h18: return m_sig;
            8'h20: return {28'd0, (m_state == 1), (m_state == 2),
                           (m_ctrl[0] && m_ctrl[1] && m_state == 0), m_ctrl[0]};
            8'h24: return m_ctrl;
            8'h28: return (m_ibideq << 16) | (m_swdeq << 8) | m_enq;
            8'h2C: return m_hwdeq;
            default: return 0;
        endcase
    endfunction

    function automatic string addr_req(logic [7:0] a);
        case (a)
            8'h00: return "R1";
            8'h10, 8'h14: return "R9";
            8'h18: return "R11";
            8'h1C: return "R10";
            8'h20: return "R8";
            8'h24: return "R7";
            8'h28: return "R2";
            8'h2C: return "R3";
            default: return "R12";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_size = 0; m_ctrl = 0; m_enq = 0; m_swdeq = 0; m_ibideq = 0;
            m_hwdeq = 0; m_state = 0; m_sts = 0; m_sen = 0; m_sig = 0;
        end else begin
            m_wr  = bus_valid && bus_write;
            m_acc = eng_consume && m_pending();
            m_opd = (m_state == 1);
            m_set = 0;
            if (m_acc) m_set[11] = 1'b1;
            if (m_opd) m_set[10] = 1'b1;
            m_set = m_set & m_sen;
            m_clr = 0;
            if (m_wr && bus_addr == 8'h1C) m_set = m_set | (bus_wdata & M_MASK);
            if (m_wr && bus_addr == 8'h10) m_clr = bus_wdata & M_MASK;
            m_sts = (m_sts & ~m_clr) | m_set;
            if (!m_ctrl[0]) m_hwdeq = 0;
            else if (m_acc) m_hwdeq = m_next(m_hwdeq);
            m_nstate = m_state;
            if (m_state == 1) m_nstate = 2;
            else if (m_wr && bus_addr == 8'h24) begin
                if (m_state == 0 && bus_wdata[2]) m_nstate = 1;
                if (m_state == 2 && !bus_wdata[2]) m_nstate = 0;
            end
            m_state = m_nstate;
            if (m_wr) begin
                case (bus_addr)
                    8'h00: m_size = bus_wdata[8:0];
                    8'h14: m_sen = bus_wdata & M_MASK;
                    8'h18: m_sig = bus_wdata & M_MASK;
                    8'h24: m_ctrl = bus_wdata[2:0];
                    8'h28: begin
                        m_enq = bus_wdata[7:0];
                        m_swdeq = bus_wdata[15:8];
                        m_ibideq = bus_wdata[23:16];
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        if (!rst) begin
            chk(32'(cmd_pending), 32'(m_pending()), "R4");
            chk(32'(irq), 32'(|(m_sts & m_sig)), "R11");
            chk(bus_rdata, m_read(bus_addr), addr_req(bus_addr));
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic pulse();
        eng_consume = 1'b1;
        tick();
        eng_consume = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(v, exp, req);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        rd_chk(8'h00, 0, "R1"); rd_chk(8'h10, 0, "R1"); rd_chk(8'h24, 0, "R1");
        rd_chk(8'h28, 0, "R1"); rd_chk(8'h2C, 0, "R1");
        chk(32'(cmd_pending), 0, "R1"); chk(32'(irq), 0, "R1");

        wr(8'h00, 32'hFFFF_FE05);
        rd_chk(8'h00, 32'h0000_0005, "R1");
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk(8'h14, 32'h0000_1EE0, "R12");
        rd_chk(8'h40, 0, "R12");
        wr(8'h18, 32'h0000_0800);
        wr(8'h28, 32'hFFAA_0103);
        rd_chk(8'h28, 32'h00AA_0103, "R2");
        wr(8'h2C, 32'h00FF_00FF);
        rd_chk(8'h2C, 0, "R3");

        // R5 consume ignored while stopped
        pulse();
        rd_chk(8'h2C, 0, "R5");
        rd_chk(8'h10, 0, "R5");

        wr(8'h24, 32'h3);
        chk(32'(cmd_pending), 1, "R4");
        rd_chk(8'h20, 32'h3, "R8");

        repeat (3) pulse();
        rd_chk(8'h2C, 3, "R5");
        chk(32'(cmd_pending), 0, "R4");
        rd_chk(8'h10, 32'h0000_0800, "R9");
        chk(32'(irq), 1, "R11");
        pulse();
        rd_chk(8'h2C, 3, "R5");

        wr(8'h10, 32'h0000_0800);
        rd_chk(8'h10, 0, "R9");
        chk(32'(irq), 0, "R11");

        // wrap at size 5: 3 -> 4 -> 0 -> 1
        wr(8'h28, 32'h00AA_0101);
        repeat (2) pulse();
        rd_chk(8'h2C, 0, "R5");
        pulse();
        rd_chk(8'h2C, 1, "R5");
        chk(32'(cmd_pending), 0, "R4");
        wr(8'h10, 32'hFFFF_FFFF);

        // status-enable gating
        wr(8'h14, 32'h0);
        wr(8'h28, 32'h00AA_0102);
        pulse();
        rd_chk(8'h2C, 2, "R5");
        rd_chk(8'h10, 0, "R9");

        // force
        wr(8'h1C, 32'h0000_1000);
        rd_chk(8'h10, 32'h0000_1000, "R10");
        rd_chk(8'h1C, 0, "R10");
        wr(8'h1C, 32'h0000_0201);
        rd_chk(8'h10, 32'h0000_1200, "R10");
        chk(32'(irq), 0, "R11");
        wr(8'h10, 32'hFFFF_FFFF);
        rd_chk(8'h10, 0, "R9");
        wr(8'h14, 32'hFFFF_FFFF);

        // set wins over write-one clear in the same cycle
        wr(8'h28, 32'h00AA_0104);
        eng_consume = 1'b1;
        wr(8'h10, 32'h0000_0800);
        eng_consume = 1'b0;
        rd_chk(8'h10, 32'h0000_0800, "R9");
        wr(8'h10, 32'hFFFF_FFFF);

        // abort sequence
        wr(8'h24, 32'h7);
        rd_chk(8'h20, 32'h9, "R7");
        rd_chk(8'h10, 0, "R7");
        chk(32'(cmd_pending), 0, "R7");
        tick();
        rd_chk(8'h20, 32'h5, "R7");
        rd_chk(8'h10, 32'h0000_0400, "R7");
        pulse();
        rd_chk(8'h2C, 3, "R7");
        wr(8'h24, 32'h3);
        rd_chk(8'h20, 32'h3, "R7");
        chk(32'(cmd_pending), 1, "R4");

        // enable clear resets hardware pointer
        wr(8'h24, 32'h0);
        tick();
        rd_chk(8'h2C, 0, "R6");
        rd_chk(8'h20, 0, "R8");

        repeat (4) tick();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(2 * HALF * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule